// File: doc/BRIEF.md
# Frame-Dropping Store-and-Forward Clock-Crossing Frame Buffer

This block carries whole byte-wide frames from a fast write clock domain into a slower, unrelated read clock domain. On the write side, a byte stream arrives with start-of-frame, end-of-frame and error markers. On the read side, a byte stream leaves with a ready/valid handshake and the same frame markers. A frame becomes visible to the reader only after its last byte has been stored without error. Partial frames therefore never reach the output.

The write side keeps watch on how full the buffer is, and the fill level has hysteresis. Once the fill passes an upper threshold, new frames are thrown away whole until the reader has drained the fill below a lower threshold. A frame that was already being written when the upper threshold was crossed is still completed. If the storage runs out in the middle of a frame, that frame is rolled back. Errored frames are rolled back as well. Each frame that is thrown away or rolled back adds one to a saturating drop counter in the write domain.

Bytes are committed to a write pointer only at a clean frame end. The committed pointer crosses to the read domain in Gray code through a two-flop synchronizer. The read pointer crosses back to the write domain the same way. The default depth of 4096 bytes holds two maximum-length 1518-byte frames back to back.

Top module: `sf_frame_cdc_fifo`

## Requirements
- R1: After reset, `rd_valid_o` is 0 and `drop_cnt_o` is 0.
- R2: Each accepted frame is delivered byte for byte and in order. `rd_sof_o` is 1 on its first byte and `rd_eof_o` is 1 on its last byte. A one-byte frame shows both flags on the same byte.
- R3: No byte of a frame appears on the read side before the frame's end-of-frame byte has been written.
- R4: A frame whose end-of-frame byte carries `wr_err_i`=1 is not delivered and increments `drop_cnt_o` by one. The frames before and after it are delivered intact.
- R5: A frame that starts while the write-side fill (bytes written minus bytes read) is above `HI_TH` is dropped whole and increments `drop_cnt_o` by one.
- R6: After dropping begins, frames stay dropped until the fill falls below `LO_TH`. A fill between the two thresholds keeps dropping.
- R7: A frame that was accepted at its start is completed and delivered even if the fill crosses `HI_TH` while it is being written.
- R8: A frame that does not fit in the free storage is rolled back and counted in `drop_cnt_o`. The stored fill never exceeds the depth of 2^`ADDR_W` bytes. The next frame is accepted normally.
- R9: Bytes that arrive with `wr_valid_i`=1 outside a frame (no start marker, and no frame open) are ignored.
- R10: While `rd_valid_o`=1 and `rd_ready_i`=0, the read-side data and flags hold their values. No byte is lost or repeated under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write-domain clock |
| rd_clk_i | input | 1 | Read-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid_i | input | 1 | Write byte valid |
| wr_sof_i | input | 1 | Write byte is the first byte of a frame |
| wr_eof_i | input | 1 | Write byte is the last byte of a frame |
| wr_err_i | input | 1 | Frame is errored; sampled together with `wr_eof_i` |
| wr_data_i | input | 8 | Write byte |
| drop_cnt_o | output | DROP_W | Saturating count of discarded frames (write domain) |
| rd_ready_i | input | 1 | Reader accepts the current byte |
| rd_valid_o | output | 1 | Read byte valid |
| rd_sof_o | output | 1 | Read byte is the first byte of a frame |
| rd_eof_o | output | 1 | Read byte is the last byte of a frame |
| rd_data_o | output | 8 | Read byte |

## Verification
The assertions assume that both domains see `rst_ni` together and that the write inputs change only between write clock edges. They also assume that `wr_err_i` is meaningful only on an end-of-frame byte, and that each clock runs freely so that Gray pointers move at most one code step per edge. The stimulus drives the write inputs on falling write clock edges and changes `rd_ready_i` just after rising read clock edges. Threshold and overflow scenarios run with the reader stalled, so that the fill level seen by the write side is exact when each frame starts.

// File: rtl/sf_cdc_pkg.sv
package sf_cdc_pkg;
  localparam int unsigned SF_BYTE_W = 8;

  typedef struct packed {
    logic                 last;
    logic [SF_BYTE_W-1:0] data;
  } sf_word_t;
endpackage

// File: rtl/sf_ptr_sync.sv
module sf_ptr_sync #(
  parameter int unsigned PW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);
  logic [PW-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_i;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    for (int i = 0; i < int'(PW); i++) bin_o[i] = ^(sync_q >> i);
  end
endmodule

// File: rtl/sf_dual_ram.sv
module sf_dual_ram
  import sf_cdc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              wr_clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  sf_word_t          wdata_i,
  input  logic              rd_clk_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output sf_word_t          rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  sf_word_t mem_q [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rd_clk_i) begin
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/sf_wr_ctrl.sv
module sf_wr_ctrl
  import sf_cdc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned HI_TH  = 3000,
  parameter int unsigned LO_TH  = 1024,
  parameter int unsigned DROP_W = 16,
  localparam int unsigned PW    = ADDR_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 sof_i,
  input  logic                 eof_i,
  input  logic                 err_i,
  input  logic [SF_BYTE_W-1:0] data_i,
  input  logic [PW-1:0]        rd_ptr_i,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_waddr_o,
  output sf_word_t             mem_wdata_o,
  output logic [PW-1:0]        pub_gray_o,
  output logic [PW-1:0]        used_o,
  output logic [DROP_W-1:0]    drop_cnt_o
);
  localparam logic [PW-1:0] DEPTH = PW'(1) << ADDR_W;
  localparam logic [PW-1:0] HI    = PW'(HI_TH);
  localparam logic [PW-1:0] LO    = PW'(LO_TH);

  logic [PW-1:0]     wr_ptr_q, commit_q, pub_q, pub_gray_q, base;
  logic              in_frame_q, take_q, bad_q, block_q;
  logic              start, active, take, fits, bad, do_wr, fin, good;
  logic [DROP_W-1:0] drop_q;

  always_comb begin
    start  = valid_i & sof_i;
    active = start | (valid_i & in_frame_q);
    // a new start abandons any open frame and begins at the commit point
    base   = start ? commit_q : wr_ptr_q;
    fits   = (base - rd_ptr_i) < DEPTH;
    take   = start ? ~block_q : take_q;
    bad    = (take & ~fits) | (~start & bad_q);
    do_wr  = active & take & ~bad;
    fin    = active & eof_i;
    good   = fin & do_wr & ~err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      commit_q   <= '0;
      in_frame_q <= 1'b0;
      take_q     <= 1'b0;
      bad_q      <= 1'b0;
      drop_q     <= '0;
    end else if (active) begin
      in_frame_q <= ~fin;
      take_q     <= take;
      bad_q      <= bad;
      if (good) begin
        commit_q <= base + PW'(1);
        wr_ptr_q <= base + PW'(1);
      end else if (fin) begin
        wr_ptr_q <= commit_q;
        if (!(&drop_q)) drop_q <= drop_q + DROP_W'(1);
      end else begin
        wr_ptr_q <= base + PW'(do_wr);
      end
    end
  end

  // publish the commit point one step per cycle so the Gray code moves one bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pub_q      <= '0;
      pub_gray_q <= '0;
    end else begin
      if (pub_q != commit_q) pub_q <= pub_q + PW'(1);
      pub_gray_q <= pub_q ^ (pub_q >> 1);
    end
  end

  assign used_o = wr_ptr_q - rd_ptr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            block_q <= 1'b0;
    else if (used_o > HI)   block_q <= 1'b1;
    else if (used_o < LO)   block_q <= 1'b0;
  end

  assign mem_we_o    = do_wr;
  assign mem_waddr_o = base[ADDR_W-1:0];
  assign mem_wdata_o = '{last: fin, data: data_i};
  assign pub_gray_o  = pub_gray_q;
  assign drop_cnt_o  = drop_q;
endmodule

// File: rtl/sf_rd_ctrl.sv
module sf_rd_ctrl
  import sf_cdc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned PW    = ADDR_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PW-1:0]        pub_ptr_i,
  input  logic                 ready_i,
  output logic                 mem_re_o,
  output logic [ADDR_W-1:0]    mem_raddr_o,
  input  sf_word_t             mem_rdata_i,
  output logic                 valid_o,
  output logic                 sof_o,
  output logic                 eof_o,
  output logic [SF_BYTE_W-1:0] data_o,
  output logic [PW-1:0]        rd_gray_o
);
  logic [PW-1:0] rd_ptr_q, rd_gray_q;
  logic          vld_q, at_start_q, avail, load;

  always_comb begin
    avail = rd_ptr_q != pub_ptr_i;
    load  = avail & (~vld_q | ready_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q   <= '0;
      rd_gray_q  <= '0;
      vld_q      <= 1'b0;
      at_start_q <= 1'b1;
    end else begin
      if (load) begin
        rd_ptr_q <= rd_ptr_q + PW'(1);
        vld_q    <= 1'b1;
      end else if (ready_i) begin
        vld_q    <= 1'b0;
      end
      if (vld_q && ready_i) at_start_q <= mem_rdata_i.last;
      rd_gray_q <= rd_ptr_q ^ (rd_ptr_q >> 1);
    end
  end

  assign mem_re_o    = load;
  assign mem_raddr_o = rd_ptr_q[ADDR_W-1:0];
  assign valid_o     = vld_q;
  assign sof_o       = vld_q & at_start_q;
  assign eof_o       = vld_q & mem_rdata_i.last;
  assign data_o      = mem_rdata_i.data;
  assign rd_gray_o   = rd_gray_q;
endmodule

// File: rtl/sf_frame_cdc_fifo.sv
module sf_frame_cdc_fifo
  import sf_cdc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned HI_TH  = 3000,
  parameter int unsigned LO_TH  = 1024,
  parameter int unsigned DROP_W = 16
) (
  input  logic                 wr_clk_i,
  input  logic                 rd_clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_valid_i,
  input  logic                 wr_sof_i,
  input  logic                 wr_eof_i,
  input  logic                 wr_err_i,
  input  logic [SF_BYTE_W-1:0] wr_data_i,
  output logic [DROP_W-1:0]    drop_cnt_o,
  input  logic                 rd_ready_i,
  output logic                 rd_valid_o,
  output logic                 rd_sof_o,
  output logic                 rd_eof_o,
  output logic [SF_BYTE_W-1:0] rd_data_o
);
  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0]     pub_gray, rd_gray, pub_ptr_r, rd_ptr_w, wr_used;
  logic              mem_we, mem_re;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  sf_word_t          mem_wdata, mem_rdata;

  sf_wr_ctrl #(
    .ADDR_W (ADDR_W),
    .HI_TH  (HI_TH),
    .LO_TH  (LO_TH),
    .DROP_W (DROP_W)
  ) u_wr (
    .clk_i       (wr_clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (wr_valid_i),
    .sof_i       (wr_sof_i),
    .eof_i       (wr_eof_i),
    .err_i       (wr_err_i),
    .data_i      (wr_data_i),
    .rd_ptr_i    (rd_ptr_w),
    .mem_we_o    (mem_we),
    .mem_waddr_o (mem_waddr),
    .mem_wdata_o (mem_wdata),
    .pub_gray_o  (pub_gray),
    .used_o      (wr_used),
    .drop_cnt_o  (drop_cnt_o)
  );

  sf_ptr_sync #(.PW(PW)) u_pub_sync (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .gray_i (pub_gray),
    .bin_o  (pub_ptr_r)
  );

  sf_ptr_sync #(.PW(PW)) u_rd_sync (
    .clk_i  (wr_clk_i),
    .rst_ni (rst_ni),
    .gray_i (rd_gray),
    .bin_o  (rd_ptr_w)
  );

  sf_dual_ram #(.ADDR_W(ADDR_W)) u_ram (
    .wr_clk_i (wr_clk_i),
    .we_i     (mem_we),
    .waddr_i  (mem_waddr),
    .wdata_i  (mem_wdata),
    .rd_clk_i (rd_clk_i),
    .re_i     (mem_re),
    .raddr_i  (mem_raddr),
    .rdata_o  (mem_rdata)
  );

  sf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i       (rd_clk_i),
    .rst_ni      (rst_ni),
    .pub_ptr_i   (pub_ptr_r),
    .ready_i     (rd_ready_i),
    .mem_re_o    (mem_re),
    .mem_raddr_o (mem_raddr),
    .mem_rdata_i (mem_rdata),
    .valid_o     (rd_valid_o),
    .sof_o       (rd_sof_o),
    .eof_o       (rd_eof_o),
    .data_o      (rd_data_o),
    .rd_gray_o   (rd_gray)
  );
endmodule

// File: rtl/sf_frame_cdc_fifo_chk.sv
module sf_frame_cdc_fifo_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DROP_W = 16,
  localparam int unsigned PW    = ADDR_W + 1
) (
  input logic              wr_clk_i,
  input logic              rd_clk_i,
  input logic              rst_ni,
  input logic [PW-1:0]     wr_used,
  input logic [PW-1:0]     pub_gray,
  input logic [PW-1:0]     rd_gray,
  input logic [DROP_W-1:0] drop_cnt_o,
  input logic              rd_ready_i,
  input logic              rd_valid_o,
  input logic              rd_sof_o,
  input logic              rd_eof_o,
  input logic [7:0]        rd_data_o
);
  localparam logic [PW-1:0] DEPTH = PW'(1) << ADDR_W;

  p_no_overflow_r8: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wr_used <= DEPTH);

  p_hold_stall_r10: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o)
                                  && $stable(rd_sof_o) && $stable(rd_eof_o));

  p_sof_after_eof_r2: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_valid_o && rd_ready_i && rd_eof_o |=> !rd_valid_o || rd_sof_o);

  p_pub_gray_step_r3: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    $countones(pub_gray ^ $past(pub_gray)) <= 1);

  p_rd_gray_step_r3: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);

  p_drop_monotonic_r4: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    drop_cnt_o >= $past(drop_cnt_o));
endmodule

bind sf_frame_cdc_fifo sf_frame_cdc_fifo_chk #(
  .ADDR_W (ADDR_W),
  .DROP_W (DROP_W)
) u_chk (
  .wr_clk_i   (wr_clk_i),
  .rd_clk_i   (rd_clk_i),
  .rst_ni     (rst_ni),
  .wr_used    (wr_used),
  .pub_gray   (pub_gray),
  .rd_gray    (rd_gray),
  .drop_cnt_o (drop_cnt_o),
  .rd_ready_i (rd_ready_i),
  .rd_valid_o (rd_valid_o),
  .rd_sof_o   (rd_sof_o),
  .rd_eof_o   (rd_eof_o),
  .rd_data_o  (rd_data_o)
);

// File: tb/tb_sf_frame_cdc_fifo.sv
module tb_sf_frame_cdc_fifo;
  localparam int WR_PERIOD = 8;
  localparam int RD_PERIOD = 14;
  localparam int AW = 6;
  localparam int HI = 40;
  localparam int LO = 20;
  localparam int DW = 8;

  logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic          wr_valid = 1'b0, wr_sof = 1'b0, wr_eof = 1'b0, wr_err = 1'b0;
  logic [7:0]    wr_data = '0;
  logic          rd_ready = 1'b0;
  logic [DW-1:0] drop_cnt;
  logic          rd_valid, rd_sof, rd_eof;
  logic [7:0]    rd_data;

  logic [9:0] exp_q[$];
  logic [9:0] rx_q[$];
  int checks = 0, fails = 0, drops = 0;
  bit done = 0;

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  sf_frame_cdc_fifo #(.ADDR_W(AW), .HI_TH(HI), .LO_TH(LO), .DROP_W(DW)) dut (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_sof_i(wr_sof), .wr_eof_i(wr_eof), .wr_err_i(wr_err),
    .wr_data_i(wr_data), .drop_cnt_o(drop_cnt), .rd_ready_i(rd_ready),
    .rd_valid_o(rd_valid), .rd_sof_o(rd_sof), .rd_eof_o(rd_eof), .rd_data_o(rd_data)
  );

  always @(negedge rd_clk)
    if (rst_n && rd_valid && rd_ready) rx_q.push_back({rd_sof, rd_eof, rd_data});

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_wr(input int n);
    repeat (n) @(negedge wr_clk);
  endtask

  task automatic set_ready(input logic v);
    @(posedge rd_clk); #1; rd_ready = v;
  endtask

  task automatic read_n(input int n);
    int tgt = rx_q.size() + n;
    @(posedge rd_clk); #1; rd_ready = 1'b1;
    while (rx_q.size() < tgt) begin @(posedge rd_clk); #1; end
    rd_ready = 1'b0;
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed, input bit err,
                            input int gap, input bit keep);
    for (int i = 0; i < len; i++) begin
      @(negedge wr_clk);
      wr_valid = 1'b1; wr_sof = (i == 0); wr_eof = (i == len - 1);
      wr_err = err && (i == len - 1); wr_data = seed + 8'(i);
      if (keep) exp_q.push_back({(i == 0), (i == len - 1), seed + 8'(i)});
      repeat (gap) begin @(negedge wr_clk); wr_valid = 1'b0; end
    end
    @(negedge wr_clk);
    wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0; wr_err = 1'b0;
  endtask

  task automatic verify(input string req);
    bit ok;
    int bad_i = -1;
    set_ready(1'b1);
    repeat (300) @(negedge rd_clk);
    ok = (rx_q.size() == exp_q.size());
    if (ok)
      for (int i = 0; i < rx_q.size(); i++)
        if (rx_q[i] !== exp_q[i] && bad_i < 0) begin bad_i = i; ok = 0; end
    if (bad_i >= 0) chk(ok, {req, " stream"}, int'(rx_q[bad_i]), int'(exp_q[bad_i]));
    else            chk(ok, {req, " stream length"}, rx_q.size(), exp_q.size());
    rx_q.delete();
    exp_q.delete();
  endtask

  task automatic chk_drop(input string req);
    @(negedge wr_clk);
    chk(int'(drop_cnt) == drops, {req, " drop count"}, int'(drop_cnt), drops);
  endtask

  task automatic t_reset();
    @(negedge rd_clk);
    chk(rd_valid == 1'b0, "R1 valid", int'(rd_valid), 0);
    chk(drop_cnt == '0, "R1 drop", int'(drop_cnt), 0);
  endtask

  task automatic t_basic();
    set_ready(1'b1);
    send_frame(1, 8'h11, 0, 0, 1);
    send_frame(2, 8'h20, 0, 0, 1);
    send_frame(17, 8'h40, 0, 0, 1);
    verify("R2");
  endtask

  task automatic t_store_forward();
    set_ready(1'b1);
    for (int i = 0; i < 10; i++) begin
      @(negedge wr_clk);
      wr_valid = 1'b1; wr_sof = (i == 0); wr_eof = 1'b0; wr_data = 8'h60 + 8'(i);
      exp_q.push_back({(i == 0), 1'b0, 8'h60 + 8'(i)});
      repeat (2) begin @(negedge wr_clk); wr_valid = 1'b0; end
    end
    idle_wr(40);
    @(negedge rd_clk);
    chk(rd_valid == 1'b0, "R3 no early valid", int'(rd_valid), 0);
    chk(rx_q.size() == 0, "R3 no early bytes", rx_q.size(), 0);
    @(negedge wr_clk);
    wr_valid = 1'b1; wr_eof = 1'b1; wr_data = 8'h6a;
    exp_q.push_back({1'b0, 1'b1, 8'h6a});
    @(negedge wr_clk);
    wr_valid = 1'b0; wr_eof = 1'b0;
    verify("R3");
  endtask

  task automatic t_error();
    send_frame(6, 8'h70, 0, 0, 1);
    send_frame(10, 8'h80, 1, 0, 0);
    drops++;
    send_frame(7, 8'h90, 0, 0, 1);
    chk_drop("R4");
    verify("R4");
  endtask

  task automatic t_hysteresis();
    set_ready(1'b0);
    idle_wr(20);
    send_frame(15, 8'h10, 0, 0, 1);
    idle_wr(40);
    send_frame(15, 8'h30, 0, 0, 1);
    idle_wr(40);
    send_frame(15, 8'h50, 0, 0, 1);   // crosses HI mid-frame (R7)
    idle_wr(40);
    send_frame(15, 8'h70, 0, 0, 0);
    drops++;
    chk_drop("R5");
    read_n(15);
    idle_wr(40);
    send_frame(15, 8'h90, 0, 0, 0);   // fill between LO and HI
    drops++;
    chk_drop("R6 still dropping");
    read_n(15);
    idle_wr(40);
    send_frame(15, 8'hb0, 0, 0, 1);
    chk_drop("R6 resumed");
    // the first 30 bytes are already in rx_q, matching the head of exp_q
    verify("R7");
  endtask

  task automatic t_overflow();
    set_ready(1'b0);
    idle_wr(20);
    send_frame(70, 8'h00, 0, 0, 0);
    drops++;
    chk_drop("R8 rollback");
    idle_wr(10);
    send_frame(8, 8'hc0, 0, 0, 1);
    chk_drop("R8 next accepted");
    verify("R8");
  endtask

  task automatic t_stray();
    set_ready(1'b1);
    for (int i = 0; i < 5; i++) begin
      @(negedge wr_clk);
      wr_valid = 1'b1; wr_sof = 1'b0; wr_eof = (i == 4); wr_data = 8'he0 + 8'(i);
    end
    @(negedge wr_clk);
    wr_valid = 1'b0; wr_eof = 1'b0;
    chk_drop("R9");
    idle_wr(60);
    @(negedge rd_clk);
    chk(rx_q.size() == 0, "R9 no output", rx_q.size(), 0);
    send_frame(4, 8'hd0, 0, 0, 1);
    verify("R9");
  endtask

  task automatic t_backpressure();
    fork
      begin
        send_frame(9, 8'h01, 0, 0, 1);
        send_frame(9, 8'h21, 0, 1, 1);
        send_frame(9, 8'h41, 0, 0, 1);
      end
      begin
        for (int i = 0; i < 150; i++) set_ready(i % 3 == 0);
      end
    join
    verify("R10");
  endtask

  initial begin
    #(WR_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge wr_clk);
    rst_n = 1'b1;
    idle_wr(5);
    t_reset();
    t_basic();
    t_store_forward();
    t_error();
    t_hysteresis();
    t_overflow();
    t_stray();
    t_backpressure();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule